// File: doc/BRIEF.md
# Triggered Interval Meter

This block measures one interval on a digital input and reports it as a 16-bit count of reference ticks. A host arms it with a one-cycle software strobe or with an edge on an external trigger pin. Once armed, the block waits for the next point where the measured input becomes active and does not use an interval that was already in progress. It then counts the cycles on which the reference enable is high. It stops at the end of the pulse (width mode) or at the next active start (period mode).

When the interval ends, the count is copied into a result register. At the same time a sticky done flag is set and a single-cycle interrupt request is raised. The block then goes idle and ignores the input until it is armed again. The measured time is the count multiplied by the period of the reference enable.

A count that reaches the top of its range stays there and raises an overflow flag. Both polarities are programmable: the measured input can be active high, active low or disabled, and the external trigger can fire on its rising edge, on its falling edge or not at all.

Top module: `interval_meter`

## Requirements
- R1: After reset, busy, done, irq and overflow are 0 and result is 0.
- R2: An accepted trigger makes busy 1 on the next cycle. A trigger is accepted only while busy is 0 and mode is 3'b010 (width) or 3'b011 (period); with any other mode code a trigger is ignored and busy stays 0. A trigger is a high sw_trig, or an edge on trig_in chosen by trig_pol: 2'b10 fires on a rising edge, 2'b01 fires on a falling edge, and 2'b00 or 2'b11 never fire.
- R3: In width mode the result equals the number of clock edges with ref_en high, counted from the first edge that samples sig_in active through the last edge that samples it active.
- R4: In period mode the result equals the number of clock edges with ref_en high, counted from the first edge that samples sig_in active up to, but not including, the edge that samples the next inactive-to-active change.
- R5: in_pol sets the active level of sig_in: 2'b10 is active high and 2'b01 is active low. With 2'b00 or 2'b11 no measurement starts, and the armed block stays busy.
- R6: The edge that ends a measurement loads result, sets done, raises irq for exactly one cycle and clears busy. The next accepted trigger clears done.
- R7: Triggers that arrive while busy is 1 are ignored. This includes a trigger in the very cycle that ends the measurement, and a trigger in the middle of a measurement, which does not restart the count.
- R8: A count at 16'hFFFF stays at 16'hFFFF and sets overflow. The next accepted trigger clears overflow.
- R9: After a measurement completes, further activity on sig_in leaves result, done and irq unchanged until the block is armed again.
- R10: If sig_in is already active in the cycle the trigger is accepted, that pulse is not measured. Measurement begins at the next inactive-to-active change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | Reference tick enable; the counter advances only on cycles where it is high |
| sig_in | input | 1 | Input being measured (synchronous to clk) |
| trig_in | input | 1 | External trigger pin (synchronous to clk) |
| sw_trig | input | 1 | One-cycle software trigger strobe |
| mode | input | 3 | 3'b010 width, 3'b011 period, other codes refuse arming |
| in_pol | input | 2 | Active level of sig_in: 01 low, 10 high, 00/11 disabled |
| trig_pol | input | 2 | Active edge of trig_in: 01 falling, 10 rising, 00/11 disabled |
| busy | output | 1 | Armed or measuring |
| done | output | 1 | Result valid since the last trigger |
| irq | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Count saturated during the current measurement |
| result | output | 16 | Latched count of the last measurement |

## Verification
Two events can fall on the same clock edge: the arrival of a trigger and the end of the measurement. The bench provokes this by raising sw_trig in exactly the cycle that sig_in changes level to end a width measurement. The result must equal the pulse length, busy must drop and done must stay set. A second trigger one cycle later must then re-arm the block and clear done. Arming and the start edge can also coincide, and the bench checks that a pulse already active at arming is skipped and that the following pulse is measured.

// File: rtl/imeter_pkg.sv
package imeter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MEAS  = 2'd2
  } meas_state_e;

  localparam logic [2:0] MODE_WIDTH  = 3'b010;
  localparam logic [2:0] MODE_PERIOD = 3'b011;

  // Active level of a pin for a 2-bit polarity code (01 low, 10 high, else off).
  function automatic logic pol_level(input logic [1:0] pol, input logic pin);
    case (pol)
      2'b01:   return ~pin;
      2'b10:   return pin;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_valid(input logic [2:0] m);
    return (m == MODE_WIDTH) || (m == MODE_PERIOD);
  endfunction

endpackage

// File: rtl/imeter_edge.sv
module imeter_edge
  import imeter_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] pol,
  output logic       rise,
  output logic       fall
);

  logic lvl;
  logic lvl_q;

  assign lvl = pol_level(pol, pin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/imeter_ctrl.sv
module imeter_ctrl
  import imeter_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_trig,
  input  logic       trig_in,
  input  logic [1:0] trig_pol,
  input  logic [2:0] mode,
  input  logic       sig_rise,
  input  logic       sig_fall,
  output logic       busy,
  output logic       arm,
  output logic       begin_m,
  output logic       run,
  output logic       finish
);

  meas_state_e state_q;
  logic [2:0]  mode_q;
  logic        trig_q;
  logic        trig_lvl;
  logic        ext_fire;
  logic        trig_any;

  assign trig_lvl = pol_level(trig_pol, trig_in);
  assign ext_fire = trig_lvl & ~trig_q;
  assign trig_any = sw_trig | ext_fire;

  assign arm     = (state_q == ST_IDLE) && trig_any && mode_valid(mode);
  assign begin_m = (state_q == ST_ARMED) && sig_rise;
  assign finish  = (state_q == ST_MEAS) &&
                   ((mode_q == MODE_WIDTH) ? sig_fall : sig_rise);
  assign run     = (state_q == ST_MEAS) && !finish;
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_WIDTH;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= trig_lvl;
      case (state_q)
        ST_IDLE:  if (arm) begin
                    state_q <= ST_ARMED;
                    mode_q  <= mode;
                  end
        ST_ARMED: if (begin_m) state_q <= ST_MEAS;
        ST_MEAS:  if (finish)  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ARM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> busy); // R2
  AST_BAD_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !mode_valid(mode)) |=> !busy); // R2
  AST_BUSY_IGNORES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig_any && !finish) |=> busy); // R7
  AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy); // R6

endmodule

// File: rtl/imeter_count.sv
module imeter_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic         run,
  input  logic         ref_en,
  input  logic         finish,
  output logic [W-1:0] result,
  output logic         done,
  output logic         irq,
  output logic         ovf
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         hit_max;

  // Saturating increment: holds at the top code.
  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == CMAX) ? CMAX : v + 1'b1;
  endfunction

  assign hit_max = run && ref_en && (cnt_q == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else if (clear) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else if (load) begin
      cnt_q <= {{(W-1){1'b0}}, ref_en};
    end else if (run && ref_en) begin
      cnt_q <= sat_inc(cnt_q);
      if (hit_max) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= finish;
      if (finish) begin
        result <= cnt_q;
        done   <= 1'b1;
      end else if (clear) begin
        done <= 1'b0;
      end
    end
  end

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_max |=> (cnt_q == CMAX) && ovf); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R6
  AST_IRQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R6
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !done && !ovf); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result)); // R9

endmodule

// File: rtl/interval_meter.sv
module interval_meter
  import imeter_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_en,
  input  logic          sig_in,
  input  logic          trig_in,
  input  logic          sw_trig,
  input  logic [2:0]    mode,
  input  logic [1:0]    in_pol,
  input  logic [1:0]    trig_pol,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic          overflow,
  output logic [CW-1:0] result
);

  logic sig_rise;
  logic sig_fall;
  logic arm;
  logic begin_m;
  logic run;
  logic finish;

  imeter_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (sig_in),
    .pol  (in_pol),
    .rise (sig_rise),
    .fall (sig_fall)
  );

  imeter_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_trig (sw_trig),
    .trig_in (trig_in),
    .trig_pol(trig_pol),
    .mode    (mode),
    .sig_rise(sig_rise),
    .sig_fall(sig_fall),
    .busy    (busy),
    .arm     (arm),
    .begin_m (begin_m),
    .run     (run),
    .finish  (finish)
  );

  imeter_count #(.W(CW)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (arm),
    .load  (begin_m),
    .run   (run),
    .ref_en(ref_en),
    .finish(finish),
    .result(result),
    .done  (done),
    .irq   (irq),
    .ovf   (overflow)
  );

  AST_START_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sig_rise) |=> !done || $stable(result)); // R10

endmodule

// File: tb/sim_interval_meter.sv
module sim_interval_meter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b1;
  logic        sig_in = 1'b0;
  logic        trig_in = 1'b0;
  logic        sw_trig = 1'b0;
  logic [2:0]  mode = 3'b010;
  logic [1:0]  in_pol = 2'b10;
  logic [1:0]  trig_pol = 2'b00;
  logic        busy, done, irq, overflow;
  logic [15:0] result;

  int errors = 0;
  int checks = 0;
  bit ended = 0;

  localparam logic [2:0] MW = 3'b010;
  localparam logic [2:0] MP = 3'b011;

  always #10 clk = ~clk;

  interval_meter u0 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .sig_in(sig_in),
    .trig_in(trig_in), .sw_trig(sw_trig), .mode(mode), .in_pol(in_pol),
    .trig_pol(trig_pol), .busy(busy), .done(done), .irq(irq),
    .overflow(overflow), .result(result)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic act_lvl(input logic [1:0] pol);
    return (pol == 2'b10);
  endfunction

  task automatic strobe();
    sw_trig = 1'b1; tick(1); sw_trig = 1'b0;
  endtask

  // Arm, then drive h active cycles and l inactive cycles, then the ending level.
  task automatic measure(input logic [2:0] md, input logic [1:0] pol,
                         input int h, input int l, input int div);
    int exp_cnt = 0;
    mode = md; in_pol = pol; sig_in = ~act_lvl(pol); ref_en = 1'b1;
    tick(2);
    strobe();
    chk("R2 busy after trigger", busy, 1);
    tick(2);
    for (int k = 0; k < h + l; k++) begin
      sig_in = (k < h) ? act_lvl(pol) : ~act_lvl(pol);
      ref_en = (k % div == 0);
      exp_cnt += (k % div == 0) ? 1 : 0;
      tick(1);
    end
    sig_in = (md == MW) ? ~act_lvl(pol) : act_lvl(pol);
    ref_en = 1'b1;
    tick(1);
    chk(md == MW ? "R3 width result" : "R4 period result", result, exp_cnt);
    chk("R6 irq raised", irq, 1);
    chk("R6 done set", done, 1);
    chk("R6 busy cleared", busy, 0);
    tick(1);
    chk("R6 irq one cycle", irq, 0);
    sig_in = ~act_lvl(pol);
    tick(2);
  endtask

  initial begin
    tick(3);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 irq", irq, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 result", result, 0);
    rst_n = 1'b1;
    tick(2);

    // R3 / R5: width sweep, both polarities, several reference rates
    for (int p = 0; p < 2; p++)
      for (int d = 1; d <= 3; d++)
        for (int n = 1; n <= 10; n++)
          measure(MW, p == 0 ? 2'b10 : 2'b01, n, 0, d);

    // R4: period sweep
    for (int d = 1; d <= 2; d++)
      for (int h = 1; h <= 5; h++)
        for (int l = 1; l <= 5; l++)
          measure(MP, d == 1 ? 2'b10 : 2'b01, h, l, d);

    // R2: invalid mode refuses arming
    mode = 3'b000; tick(1); strobe(); tick(1);
    chk("R2 invalid mode not armed", busy, 0);
    mode = 3'b111; strobe(); tick(1);
    chk("R2 mode 7 not armed", busy, 0);

    // R2: external trigger polarities
    mode = MW; in_pol = 2'b10; sig_in = 1'b0;
    trig_pol = 2'b00; trig_in = 1'b0; tick(1); trig_in = 1'b1; tick(1);
    trig_in = 1'b0; tick(2);
    chk("R2 trig_pol 00 ignored", busy, 0);
    trig_pol = 2'b10; tick(1); trig_in = 1'b1; tick(1);
    chk("R2 rising trigger arms", busy, 1);
    sig_in = 1'b1; tick(2); sig_in = 1'b0; tick(1);
    chk("R2 rising trigger result", result, 2);
    trig_pol = 2'b01; tick(1); trig_in = 1'b0; tick(1);
    chk("R2 falling trigger arms", busy, 1);
    chk("R6 done cleared by trigger", done, 0);
    sig_in = 1'b1; tick(3); sig_in = 1'b0; tick(1);
    chk("R2 falling trigger result", result, 3);
    trig_pol = 2'b00; tick(1);

    // R7: trigger during measurement and on the finishing edge
    strobe(); tick(1);
    sig_in = 1'b1; tick(3);
    sw_trig = 1'b1; tick(1); sw_trig = 1'b0; tick(2);
    sig_in = 1'b0; sw_trig = 1'b1; tick(1); sw_trig = 1'b0;
    chk("R7 mid trigger no restart", result, 6);
    chk("R7 trigger on finish ignored busy", busy, 0);
    chk("R7 trigger on finish keeps done", done, 1);
    strobe();
    chk("R7 retrigger arms", busy, 1);
    chk("R7 retrigger clears done", done, 0);
    sig_in = 1'b1; tick(4); sig_in = 1'b0; tick(1);
    chk("R7 after retrigger result", result, 4);

    // R9: activity after completion changes nothing
    for (int k = 0; k < 3; k++) begin
      sig_in = 1'b1; tick(2); sig_in = 1'b0; tick(1);
      chk("R9 result held", result, 4);
      chk("R9 irq quiet", irq, 0);
      chk("R9 done held", done, 1);
    end

    // R10: pulse already active at arming is skipped
    sig_in = 1'b1; sw_trig = 1'b1; tick(1); sw_trig = 1'b0;
    tick(3); sig_in = 1'b0; tick(2);
    chk("R10 stays armed", busy, 1);
    chk("R10 no done", done, 0);
    sig_in = 1'b1; tick(5); sig_in = 1'b0; tick(1);
    chk("R10 next pulse measured", result, 5);

    // R5: disabled input polarity never starts
    in_pol = 2'b00; tick(1); strobe();
    for (int k = 0; k < 4; k++) begin sig_in = ~sig_in; tick(2); end
    chk("R5 disabled still busy", busy, 1);
    chk("R5 disabled no done", done, 0);
    sig_in = 1'b0; in_pol = 2'b10; tick(2);
    sig_in = 1'b1; tick(2); sig_in = 1'b0; tick(1);
    chk("R5 enabled after", result, 2);
    in_pol = 2'b11; tick(1); strobe();
    sig_in = 1'b1; tick(2); sig_in = 1'b0; tick(2);
    chk("R5 code 11 no done", done, 0);
    in_pol = 2'b10; tick(1);
    sig_in = 1'b1; tick(1); sig_in = 1'b0; tick(1);
    chk("R5 code 11 recovery", result, 1);

    // R8: saturation
    strobe(); tick(1);
    sig_in = 1'b1; tick(70000); sig_in = 1'b0; tick(1);
    chk("R8 saturated result", result, 16'hFFFF);
    chk("R8 overflow set", overflow, 1);
    strobe();
    chk("R8 overflow cleared", overflow, 0);
    sig_in = 1'b1; tick(1); sig_in = 1'b0; tick(1);
    chk("R8 normal after clear", result, 1);
    chk("R8 no overflow", overflow, 0);

    tick(2);
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

endmodule